// File: doc/BRIEF.md
# Bulk IN Transmit Endpoint

This block is the transmit side of one bulk IN endpoint in a full-speed USB device. Firmware writes packet bytes one at a time into two 64-byte packet buffers that take turns. It controls and watches the endpoint through one 8-bit control/status register. A buffer is committed for sending when it fills to the maximum packet size, or earlier when firmware asks for a short packet. A short packet may hold zero bytes.

On the other side sits a simplified serial interface engine. It raises a one-cycle token strobe for each IN token. The block answers one cycle later with DATA (plus the packet length), NAK or STALL. During a DATA answer the engine pulls bytes with a pop strobe and reports the end of the packet with a done strobe. Line coding, CRC, token decoding and data toggles are outside this block.

Top module: `bulkInEndpoint`

## Requirements
- R1: After reset the register reads 0x00000001. Bits 31:8 and bit 6 always read 0.
- R2: When 64 bytes have been written, the buffer is committed. The first token after that is answered with respKind 1 (DATA) and respLen 64. txRdData then presents the bytes in write order, and each txRdEn moves to the next byte.
- R3: Writing 1 to bit 7 commits the partly filled buffer as a short packet, including an empty one, and bit 7 reads 1. Bit 7 clears in the cycle that the packet's DATA answer is issued.
- R4: A token is answered with respKind 2 (NAK) when bit 5 is 0 and either no packet is committed or a packet is already in flight.
- R5: Bit 5 is a plain read/write bit. While it is 1, every token is answered with respKind 3 (STALL) and bit 4 becomes 1. Writing 1 to bit 4 clears it.
- R6: A pop after all bytes of the packet in flight have been taken sets bit 3. Writing 1 to bit 3 clears it.
- R7: Writing 1 to bit 2 empties both buffers, drops the packet in flight and clears bit 7. Bit 2 always reads 0.
- R8: txDone while a packet is in flight frees its buffer and sets bit 1. Writing 1 to bit 1 clears it.
- R9: Bit 0 reads 1 exactly when the buffer being filled is not committed. While both buffers are committed, a written byte is discarded and fifoWrErr pulses high for one cycle in the next cycle.
- R10: Writing 0 to bits 7, 4, 3 or 1 changes nothing. When a hardware set and a firmware clear of the same bit fall in one cycle, the bit ends up 1.
- R11: Committed packets are sent in the order they were committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrWrEn | input | 1 | Register write strobe |
| csrWrData | input | 8 | Register write data |
| csrRdData | output | 32 | Register read data |
| fifoWrEn | input | 1 | Packet byte write strobe |
| fifoWrData | input | 8 | Packet byte |
| fifoWrErr | output | 1 | Pulses when a written byte was dropped |
| inToken | input | 1 | IN token received, one-cycle pulse |
| respValid | output | 1 | Answer to a token is valid |
| respKind | output | 2 | 1 DATA, 2 NAK, 3 STALL, 0 none |
| respLen | output | 7 | Byte count of the DATA packet |
| txRdEn | input | 1 | Pop one byte of the packet in flight |
| txRdData | output | 8 | Current byte of the packet in flight |
| txDone | input | 1 | Packet in flight has been sent |

## Verification
A register write takes effect at the clock edge that samples it, and it shows on csrRdData straight after that edge. That includes the hardware flags raised by the same edge. A token's answer and fifoWrErr each appear one edge after their stimulus and last for one cycle. txRdData follows the read pointer combinationally and moves on at the edge that samples txRdEn. The bench drives every input just after a falling edge and samples just after the next falling edge. As a result, each check reads the value due exactly one rising edge after its stimulus. It never waits an open-ended number of cycles.

// File: rtl/bulkInPkg.sv
package bulkInPkg;

  typedef enum logic [1:0] {
    RESP_NONE  = 2'd0,
    RESP_DATA  = 2'd1,
    RESP_NAK   = 2'd2,
    RESP_STALL = 2'd3
  } respKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic flush;
    logic commitShort;
    logic launch;
    logic popByte;
    logic retire;
  } dpCtl_t;

endpackage

// File: rtl/bulkInDatapath.sv
module bulkInDatapath
  import bulkInPkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int DATA_W  = 8,
  localparam int PTR_W  = $clog2(MAX_PKT),
  localparam int LEN_W  = $clog2(MAX_PKT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              fifoWrEn,
  input  logic [DATA_W-1:0] fifoWrData,
  output logic              fifoWrErr,
  output logic [DATA_W-1:0] txRdData,
  output logic              fillFull,
  output logic              headFull,
  output logic [LEN_W-1:0]  headLen,
  output logic              atEnd,
  output logic              wrSel,
  output logic              rdSel
);

  logic [DATA_W-1:0] mem [2][MAX_PKT];
  logic [1:0]        full;
  logic [LEN_W-1:0]  pktLen [2];
  logic [PTR_W-1:0]  wrCnt;
  logic [LEN_W-1:0]  rdPtr;
  logic [LEN_W-1:0]  cntNext;
  logic              wrAccept, autoCommit, doCommit;

  always_comb begin
    fillFull   = full[wrSel];
    wrAccept   = fifoWrEn & ~fillFull & ~ctl.flush;
    cntNext    = LEN_W'(wrCnt) + LEN_W'(wrAccept);
    autoCommit = wrAccept && (cntNext == LEN_W'(MAX_PKT));
    doCommit   = autoCommit | (ctl.commitShort & ~fillFull);
    headFull   = full[rdSel];
    headLen    = pktLen[rdSel];
    atEnd      = (rdPtr == pktLen[rdSel]);
    txRdData   = mem[rdSel][rdPtr[PTR_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (wrAccept) mem[wrSel][wrCnt] <= fifoWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      full      <= '0;
      wrCnt     <= '0;
      rdPtr     <= '0;
      wrSel     <= 1'b0;
      rdSel     <= 1'b0;
      fifoWrErr <= 1'b0;
      for (int b = 0; b < 2; b++) pktLen[b] <= '0;
    end else begin
      fifoWrErr <= fifoWrEn & fillFull & ~ctl.flush;
      if (ctl.flush) begin
        full  <= '0;
        wrCnt <= '0;
        rdPtr <= '0;
        wrSel <= 1'b0;
        rdSel <= 1'b0;
      end else begin
        if (doCommit) begin
          full[wrSel]   <= 1'b1;
          pktLen[wrSel] <= cntNext;
          wrSel         <= ~wrSel;
          wrCnt         <= '0;
        end else if (wrAccept) begin
          wrCnt <= wrCnt + 1'b1;
        end
        if (ctl.launch)                 rdPtr <= '0;
        else if (ctl.popByte && !atEnd) rdPtr <= rdPtr + 1'b1;
        if (ctl.retire) begin
          full[rdSel] <= 1'b0;
          rdSel       <= ~rdSel;
        end
      end
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |=> (full == 2'b00)); // R7
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (fifoWrEn && fillFull && !ctl.flush) |=> $stable(wrCnt)); // R9

endmodule

// File: rtl/bulkInControl.sv
module bulkInControl
  import bulkInPkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csrWrEn,
  input  logic [7:0]       csrWrData,
  output logic [31:0]      csrRdData,
  input  logic             inToken,
  output logic             respValid,
  output logic [1:0]       respKind,
  output logic [LEN_W-1:0] respLen,
  input  logic             txRdEn,
  input  logic             txDone,
  input  logic             fillFull,
  input  logic             headFull,
  input  logic [LEN_W-1:0] headLen,
  input  logic             atEnd,
  input  logic             wrSel,
  input  logic             rdSel,
  output dpCtl_t           ctl
);

  logic tspBit, tspCommitted, tspBuf;
  logic fstBit, sstBit, turBit, tpcBit, busy;
  logic wrTsp, shortReq, stallNow, dataNow, underrunEvt, tspTaken;
  logic unusedBits;

  assign unusedBits = ^{csrWrData[6], csrWrData[0]};

  always_comb begin
    ctl.flush       = csrWrEn & csrWrData[2];
    wrTsp           = csrWrEn & csrWrData[7] & ~tspBit;
    shortReq        = (wrTsp | (tspBit & ~tspCommitted)) & ~ctl.flush;
    ctl.commitShort = shortReq & ~fillFull;
    stallNow        = inToken & fstBit;
    dataNow         = inToken & ~fstBit & ~busy & headFull & ~ctl.flush;
    ctl.launch      = dataNow;
    ctl.popByte     = txRdEn & busy & ~ctl.flush;
    ctl.retire      = txDone & busy & ~ctl.flush;
    underrunEvt     = txRdEn & busy & atEnd & ~ctl.flush;
    tspTaken        = dataNow & tspCommitted & (tspBuf == rdSel);
    csrRdData       = {24'd0, tspBit, 1'b0, fstBit, sstBit, turBit, 1'b0, tpcBit, ~fillFull};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tspBit       <= 1'b0;
      tspCommitted <= 1'b0;
      tspBuf       <= 1'b0;
      fstBit       <= 1'b0;
      sstBit       <= 1'b0;
      turBit       <= 1'b0;
      tpcBit       <= 1'b0;
      busy         <= 1'b0;
      respValid    <= 1'b0;
      respKind     <= RESP_NONE;
      respLen      <= '0;
    end else begin
      if (ctl.flush || tspTaken) begin
        tspBit       <= 1'b0;
        tspCommitted <= 1'b0;
      end else begin
        if (wrTsp) tspBit <= 1'b1;
        if (ctl.commitShort) begin
          tspCommitted <= 1'b1;
          tspBuf       <= wrSel;
        end
      end
      if (csrWrEn) fstBit <= csrWrData[5];
      if (stallNow)                      sstBit <= 1'b1;
      else if (csrWrEn && csrWrData[4])  sstBit <= 1'b0;
      if (underrunEvt)                   turBit <= 1'b1;
      else if (csrWrEn && csrWrData[3])  turBit <= 1'b0;
      if (ctl.retire)                    tpcBit <= 1'b1;
      else if (csrWrEn && csrWrData[1])  tpcBit <= 1'b0;
      if (ctl.flush || ctl.retire) busy <= 1'b0;
      else if (dataNow)            busy <= 1'b1;
      respValid <= inToken;
      if (!inToken)     respKind <= RESP_NONE;
      else if (fstBit)  respKind <= RESP_STALL;
      else if (dataNow) respKind <= RESP_DATA;
      else              respKind <= RESP_NAK;
      respLen <= dataNow ? headLen : '0;
    end
  end

  AST_DATA_NEEDS_PACKET: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respKind == RESP_DATA) |-> busy); // R2
  AST_TSP_CLEARS_ON_SEND: assert property (@(posedge clk) disable iff (!rstN)
    tspTaken |=> !tspBit); // R3
  AST_STALL_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respKind == RESP_STALL) |-> sstBit); // R5
  AST_UNDERRUN_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    underrunEvt |=> turBit); // R6
  AST_DONE_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    ctl.retire |=> tpcBit); // R8

endmodule

// File: rtl/bulkInEndpoint.sv
module bulkInEndpoint
  import bulkInPkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int DATA_W  = 8,
  localparam int LEN_W  = $clog2(MAX_PKT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csrWrEn,
  input  logic [7:0]        csrWrData,
  output logic [31:0]       csrRdData,
  input  logic              fifoWrEn,
  input  logic [DATA_W-1:0] fifoWrData,
  output logic              fifoWrErr,
  input  logic              inToken,
  output logic              respValid,
  output logic [1:0]        respKind,
  output logic [LEN_W-1:0]  respLen,
  input  logic              txRdEn,
  output logic [DATA_W-1:0] txRdData,
  input  logic              txDone
);

  dpCtl_t           ctl;
  logic             fillFull, headFull, atEnd, wrSel, rdSel;
  logic [LEN_W-1:0] headLen;

  bulkInControl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .csrWrEn(csrWrEn), .csrWrData(csrWrData), .csrRdData(csrRdData),
    .inToken(inToken), .respValid(respValid), .respKind(respKind), .respLen(respLen),
    .txRdEn(txRdEn), .txDone(txDone),
    .fillFull(fillFull), .headFull(headFull), .headLen(headLen), .atEnd(atEnd),
    .wrSel(wrSel), .rdSel(rdSel), .ctl(ctl)
  );

  bulkInDatapath #(.MAX_PKT(MAX_PKT), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData), .fifoWrErr(fifoWrErr),
    .txRdData(txRdData), .fillFull(fillFull), .headFull(headFull),
    .headLen(headLen), .atEnd(atEnd), .wrSel(wrSel), .rdSel(rdSel)
  );

endmodule

// File: tb/bulkInEndpoint_tb.sv
module bulkInEndpoint_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrWrEn = 1'b0;
  logic [7:0]  csrWrData = '0;
  logic [31:0] csrRdData;
  logic        fifoWrEn = 1'b0;
  logic [7:0]  fifoWrData = '0;
  logic        fifoWrErr;
  logic        inToken = 1'b0;
  logic        respValid;
  logic [1:0]  respKind;
  logic [6:0]  respLen;
  logic        txRdEn = 1'b0;
  logic [7:0]  txRdData;
  logic        txDone = 1'b0;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bulkInEndpoint u_dut (
    .clk(clk), .rstN(rstN),
    .csrWrEn(csrWrEn), .csrWrData(csrWrData), .csrRdData(csrRdData),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData), .fifoWrErr(fifoWrErr),
    .inToken(inToken), .respValid(respValid), .respKind(respKind), .respLen(respLen),
    .txRdEn(txRdEn), .txRdData(txRdData), .txDone(txDone)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic csrWrite(input logic [7:0] d);
    csrWrEn = 1'b1; csrWrData = d;
    @(negedge clk);
    csrWrEn = 1'b0; csrWrData = '0;
  endtask

  task automatic pushByte(input logic [7:0] d);
    fifoWrEn = 1'b1; fifoWrData = d;
    @(negedge clk);
    fifoWrEn = 1'b0;
  endtask

  task automatic pushPacket(input logic [7:0] seed, input int n);
    for (int i = 0; i < n; i++) pushByte(seed + 8'(i));
  endtask

  task automatic token(input string req, input logic [1:0] kind, input logic [6:0] len);
    inToken = 1'b1;
    @(negedge clk);
    inToken = 1'b0;
    check({req, " kind"}, {30'd0, respKind}, {30'd0, kind});
    check({req, " len"}, {25'd0, respLen}, {25'd0, len});
  endtask

  task automatic popPacket(input string req, input logic [7:0] seed, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      if (txRdData !== seed + 8'(i)) begin
        bad++;
        $display("FAIL %s byte %0d: actual 0x%0h expected 0x%0h", req, i, txRdData, seed + 8'(i));
      end
      txRdEn = 1'b1;
      @(negedge clk);
      txRdEn = 1'b0;
    end
    nChecks++;
    if (bad != 0) nFails++;
  endtask

  task automatic finishPacket;
    txDone = 1'b1;
    @(negedge clk);
    txDone = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reset csr", csrRdData, 32'h1);
    check("R1 reset resp", {31'd0, respValid}, 32'd0);
    csrWrite(8'h40);
    check("R1 reserved bit6", csrRdData, 32'h1);
  endtask

  task automatic t_nakEmpty;
    token("R4 empty NAK", 2'd2, 7'd0);
  endtask

  task automatic t_fullPacket;
    pushPacket(8'h10, 64);
    check("R9 room after one packet", csrRdData, 32'h1);
    token("R2 full DATA", 2'd1, 7'd64);
    popPacket("R2 bytes", 8'h10, 64);
    check("R6 no underrun yet", csrRdData, 32'h1);
    txRdEn = 1'b1; @(negedge clk); txRdEn = 1'b0;
    check("R6 underrun set", csrRdData, 32'h9);
    token("R4 busy NAK", 2'd2, 7'd0);
    finishPacket();
    check("R8 complete set", csrRdData, 32'hB);
    csrWrite(8'h00);
    check("R10 zero write no effect", csrRdData, 32'hB);
    csrWrite(8'h0A);
    check("R8 R6 w1c", csrRdData, 32'h1);
  endtask

  task automatic t_shortPacket;
    pushPacket(8'h40, 5);
    csrWrite(8'h80);
    check("R3 short set", csrRdData, 32'h81);
    token("R3 short DATA", 2'd1, 7'd5);
    check("R3 short cleared on send", csrRdData, 32'h1);
    popPacket("R3 short bytes", 8'h40, 5);
    finishPacket();
    csrWrite(8'h02);
    csrWrite(8'h80);
    token("R3 zero-length DATA", 2'd1, 7'd0);
    finishPacket();
    csrWrite(8'h02);
    check("R3 after zlp", csrRdData, 32'h1);
  endtask

  task automatic t_pingPong;
    pushPacket(8'h60, 64);
    pushPacket(8'hA0, 64);
    check("R9 no room", csrRdData, 32'h0);
    pushByte(8'hEE);
    check("R9 drop pulse", {31'd0, fifoWrErr}, 32'd1);
    @(negedge clk);
    check("R9 pulse one cycle", {31'd0, fifoWrErr}, 32'd0);
    token("R11 first DATA", 2'd1, 7'd64);
    popPacket("R11 first packet order", 8'h60, 64);
    finishPacket();
    check("R9 room after free", csrRdData[0], 32'd1);
    token("R11 second DATA", 2'd1, 7'd64);
    popPacket("R9 R11 second packet intact", 8'hA0, 64);
    finishPacket();
    csrWrite(8'h02);
  endtask

  task automatic t_stall;
    csrWrite(8'h20);
    check("R5 force bit", csrRdData, 32'h21);
    token("R5 STALL", 2'd3, 7'd0);
    check("R5 sent flag", csrRdData, 32'h31);
    csrWrite(8'h20);
    check("R10 sent kept", csrRdData, 32'h31);
    csrWrite(8'h30);
    check("R5 sent w1c", csrRdData, 32'h21);
    inToken = 1'b1; csrWrEn = 1'b1; csrWrData = 8'h30;
    @(negedge clk);
    inToken = 1'b0; csrWrEn = 1'b0;
    check("R10 set wins sent", csrRdData, 32'h31);
    csrWrite(8'h10);
    check("R5 released", csrRdData, 32'h1);
    token("R5 NAK after release", 2'd2, 7'd0);
  endtask

  task automatic t_flush;
    pushPacket(8'h20, 64);
    csrWrite(8'h04);
    check("R7 flush reads zero", csrRdData, 32'h1);
    token("R7 flushed NAK", 2'd2, 7'd0);
    pushPacket(8'h30, 2);
    csrWrite(8'h80);
    csrWrite(8'h04);
    check("R7 flush clears short", csrRdData, 32'h1);
    token("R7 short flushed NAK", 2'd2, 7'd0);
    pushPacket(8'h70, 3);
    csrWrite(8'h80);
    token("R7 clean after flush", 2'd1, 7'd3);
    popPacket("R7 bytes after flush", 8'h70, 3);
    finishPacket();
    csrWrite(8'h02);
  endtask

  task automatic t_setWinsDone;
    csrWrite(8'h80);
    token("R10 zlp for race", 2'd1, 7'd0);
    txDone = 1'b1; csrWrEn = 1'b1; csrWrData = 8'h02;
    @(negedge clk);
    txDone = 1'b0; csrWrEn = 1'b0;
    check("R10 set wins complete", csrRdData, 32'h3);
    csrWrite(8'h02);
    check("R8 cleared", csrRdData, 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_nakEmpty();
    t_fullPacket();
    t_shortPacket();
    t_pingPong();
    t_stall();
    t_flush();
    t_setWinsDone();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule